// File: doc/BRIEF.md
# Element and Subvector Step Sequencer

This block walks the four loop counters of a vector operation: the source element step, the destination element step, and one subvector step for each side. A start strobe latches the vector length (VL) and the subvector length (SUBVL, 1 to 4). It also latches two independent nesting controls and the issue mode, then clears every counter. Each accepted advance moves both sides one position through their loops. When the last position has been consumed, a one-cycle done pulse is raised and the block returns to idle with all counters at zero.

Each side has its own nesting control. On the source side the pack control picks the nesting order. On the destination side the unpack control does the same. By default the subvector step is the inner loop. With the control set, the element step becomes the inner loop. In horizontal mode every element-issue strobe is an advance. In vertical-first mode only an explicit step request advances the counters. Predication and index remapping belong to other blocks.

Top module: `ss_step_seq`

## Requirements
- R1: After reset the block is idle: busy_o and done_o are 0 and all four step outputs are 0.
- R2: One cycle after start_i with vl_i > 0, busy_o is 1 and all four step outputs are 0.
- R3: With pack clear, the source subvector step is the inner loop. It counts 0..SUBVL-1, and when it wraps to 0 the source element step increments.
- R4: With pack set, the source element step is the inner loop. It counts 0..VL-1, and when it wraps to 0 the source subvector step increments.
- R5: The unpack control selects the destination nesting order in the same way. Clear means the subvector step is inner; set means the element step is inner. The choice is independent of pack.
- R6: In horizontal mode (vfirst_i = 0 at start) each cycle with issue_i = 1 is one advance, and step_i has no effect.
- R7: In vertical-first mode (vfirst_i = 1 at start) only step_i = 1 advances, and issue_i has no effect.
- R8: The cycle after the advance taken at the final position (element step VL-1 and substep SUBVL-1 on both sides), done_o is 1 for exactly one cycle. In that cycle busy_o is 0 and all step outputs are 0. A full loop takes exactly VL*SUBVL advances.
- R9: A start with vl_i = 0 raises done_o on the next cycle, and busy_o stays 0.
- R10: subvl_i is a 2-bit code: SUBVL = subvl_i + 1. While busy, element steps stay below VL and substeps stay below SUBVL.
- R11: A start while busy restarts the loop: the new configuration is taken and all counters return to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch configuration and begin a loop |
| vl_i | input | VL_W | Vector length, 0..MAX_VL |
| subvl_i | input | 2 | Subvector length minus one |
| pack_i | input | 1 | Source side: element step is inner loop |
| unpack_i | input | 1 | Destination side: element step is inner loop |
| vfirst_i | input | 1 | Vertical-first mode select |
| issue_i | input | 1 | Element issue strobe (horizontal mode advance) |
| step_i | input | 1 | Explicit step request (vertical-first advance) |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |
| srcstep_o | output | VL_W | Source element step |
| dststep_o | output | VL_W | Destination element step |
| ssubstep_o | output | 2 | Source subvector step |
| dsubstep_o | output | 2 | Destination subvector step |

## Verification
The range and nesting properties assume that vl_i never exceeds MAX_VL when start_i is applied. An out-of-range length would let the element counters climb past the parameterised bound. The stimulus sweeps VL only from 0 to 5 on the default MAX_VL of 64, so this assumption always holds. The hold properties take the mode and the nesting order as constant between starts. They are, because the configuration is latched only on start_i. The bench also applies the strobe that the current mode ignores on cycles of its own, so each hold check is exercised without an advance landing in the same cycle.

// File: rtl/ss_step_pkg.sv
package ss_step_pkg;
  typedef enum logic {
    NEST_SUB_INNER  = 1'b0,
    NEST_ELEM_INNER = 1'b1
  } nest_e;

  typedef enum logic {
    MODE_HORIZ  = 1'b0,
    MODE_VFIRST = 1'b1
  } mode_e;

  localparam int unsigned SUB_W = 2;
endpackage

// File: rtl/ss_nest_ctr.sv
module ss_nest_ctr
  import ss_step_pkg::*;
#(
  parameter int unsigned VL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  nest_e            order_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [SUB_W-1:0] sub_last_i,
  output logic [VL_W-1:0]  elem_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             last_o
);
  logic [VL_W-1:0]  elem_q, elem_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             elem_hit, sub_hit;

  assign elem_hit = (elem_q == vl_i - VL_W'(1));
  assign sub_hit  = (sub_q == sub_last_i);
  assign last_o   = elem_hit && sub_hit;

  always_comb begin
    elem_d = elem_q;
    sub_d  = sub_q;
    if (clear_i) begin
      elem_d = '0;
      sub_d  = '0;
    end else if (adv_i) begin
      if (order_i == NEST_SUB_INNER) begin
        if (sub_hit) begin
          sub_d  = '0;
          elem_d = elem_hit ? '0 : elem_q + VL_W'(1);
        end else begin
          sub_d = sub_q + SUB_W'(1);
        end
      end else begin
        if (elem_hit) begin
          elem_d = '0;
          sub_d  = sub_hit ? '0 : sub_q + SUB_W'(1);
        end else begin
          elem_d = elem_q + VL_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elem_q <= '0;
      sub_q  <= '0;
    end else begin
      elem_q <= elem_d;
      sub_q  <= sub_d;
    end
  end

  assign elem_o = elem_q;
  assign sub_o  = sub_q;
endmodule

// File: rtl/ss_step_ctrl.sv
module ss_step_ctrl
  import ss_step_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  vl_zero_i,
  input  mode_e mode_i,
  input  logic  issue_i,
  input  logic  step_i,
  input  logic  last_i,
  output logic  adv_o,
  output logic  clear_o,
  output logic  busy_o,
  output logic  done_o
);
  logic busy_q, done_q, req;

  assign req     = (mode_i == MODE_VFIRST) ? step_i : issue_i;
  assign adv_o   = busy_q && !start_i && req;
  assign clear_o = start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (start_i && vl_zero_i) || (adv_o && last_i);
      if (start_i)               busy_q <= !vl_zero_i;
      else if (adv_o && last_i)  busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/ss_step_seq.sv
module ss_step_seq
  import ss_step_pkg::*;
#(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [1:0]      subvl_i,
  input  logic            pack_i,
  input  logic            unpack_i,
  input  logic            vfirst_i,
  input  logic            issue_i,
  input  logic            step_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [VL_W-1:0] srcstep_o,
  output logic [VL_W-1:0] dststep_o,
  output logic [1:0]      ssubstep_o,
  output logic [1:0]      dsubstep_o
);
  localparam int unsigned N_SIDE = 2;  // 0: source, 1: destination

  logic [VL_W-1:0]  vl_q;
  logic [SUB_W-1:0] sub_last_q;
  logic             pack_q, unpack_q;
  mode_e            mode_q;
  logic             adv, clear;

  nest_e            order [N_SIDE];
  logic [VL_W-1:0]  elem  [N_SIDE];
  logic [SUB_W-1:0] sub   [N_SIDE];
  logic [N_SIDE-1:0] last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q       <= '0;
      sub_last_q <= '0;
      pack_q     <= 1'b0;
      unpack_q   <= 1'b0;
      mode_q     <= MODE_HORIZ;
    end else if (start_i) begin
      vl_q       <= vl_i;
      sub_last_q <= subvl_i;
      pack_q     <= pack_i;
      unpack_q   <= unpack_i;
      mode_q     <= vfirst_i ? MODE_VFIRST : MODE_HORIZ;
    end
  end

  assign order[0] = pack_q   ? NEST_ELEM_INNER : NEST_SUB_INNER;
  assign order[1] = unpack_q ? NEST_ELEM_INNER : NEST_SUB_INNER;

  for (genvar g = 0; g < N_SIDE; g++) begin : gen_side
    ss_nest_ctr #(.VL_W(VL_W)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear),
      .adv_i      (adv),
      .order_i    (order[g]),
      .vl_i       (vl_q),
      .sub_last_i (sub_last_q),
      .elem_o     (elem[g]),
      .sub_o      (sub[g]),
      .last_o     (last[g])
    );
  end

  ss_step_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .vl_zero_i (vl_i == '0),
    .mode_i    (mode_q),
    .issue_i   (issue_i),
    .step_i    (step_i),
    .last_i    (last[0]),
    .adv_o     (adv),
    .clear_o   (clear),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assign srcstep_o  = elem[0];
  assign dststep_o  = elem[1];
  assign ssubstep_o = sub[0];
  assign dsubstep_o = sub[1];
endmodule

// File: rtl/ss_step_seq_chk.sv
module ss_step_seq_chk #(
  parameter int unsigned VL_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [VL_W-1:0] vl_i,
  input logic            issue_i,
  input logic            step_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [VL_W-1:0] srcstep_o,
  input logic [VL_W-1:0] dststep_o,
  input logic [1:0]      ssubstep_o,
  input logic [1:0]      dsubstep_o,
  input logic [VL_W-1:0] vl_q,
  input logic [1:0]      sub_last_q,
  input logic            pack_q,
  input logic            unpack_q,
  input logic            vf_q,
  input logic            adv,
  input logic            src_last,
  input logic            dst_last
);
  AST_SRC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (srcstep_o < vl_q) && (ssubstep_o <= sub_last_q)); // R10
  AST_DST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (dststep_o < vl_q) && (dsubstep_o <= sub_last_q)); // R10
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> srcstep_o == '0 && dststep_o == '0 && ssubstep_o == '0 && dsubstep_o == '0); // R11
  AST_SRC_SUB_INNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !pack_q && ssubstep_o != sub_last_q |=>
      ssubstep_o == 2'($past(ssubstep_o) + 2'd1) && $stable(srcstep_o)); // R3
  AST_SRC_ELEM_INNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && pack_q && srcstep_o != vl_q - VL_W'(1) |=>
      srcstep_o == VL_W'($past(srcstep_o) + VL_W'(1)) && $stable(ssubstep_o)); // R4
  AST_DST_ELEM_INNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && unpack_q && dststep_o != vl_q - VL_W'(1) |=>
      dststep_o == VL_W'($past(dststep_o) + VL_W'(1)) && $stable(dsubstep_o)); // R5
  AST_HZ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !vf_q && !issue_i && !start_i |=>
      $stable(srcstep_o) && $stable(ssubstep_o) && $stable(dststep_o) && $stable(dsubstep_o)); // R6
  AST_VF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && vf_q && !step_i && !start_i |=>
      $stable(srcstep_o) && $stable(ssubstep_o) && $stable(dststep_o) && $stable(dsubstep_o)); // R7
  AST_LAST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> src_last == dst_last); // R8
  AST_DONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && srcstep_o == '0 && dststep_o == '0
               && ssubstep_o == '0 && dsubstep_o == '0); // R8
  AST_ZERO_VL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && vl_i == '0 |=> done_o && !busy_o); // R9
endmodule

bind ss_step_seq ss_step_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .vl_i       (vl_i),
  .issue_i    (issue_i),
  .step_i     (step_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .srcstep_o  (srcstep_o),
  .dststep_o  (dststep_o),
  .ssubstep_o (ssubstep_o),
  .dsubstep_o (dsubstep_o),
  .vl_q       (vl_q),
  .sub_last_q (sub_last_q),
  .pack_q     (pack_q),
  .unpack_q   (unpack_q),
  .vf_q       (mode_q == ss_step_pkg::MODE_VFIRST),
  .adv        (adv),
  .src_last   (last[0]),
  .dst_last   (last[1])
);

// File: tb/tb_ss_step_seq.sv
module tb_ss_step_seq;
  localparam int unsigned MAX_VL = 64;
  localparam int unsigned VL_W   = $clog2(MAX_VL + 1);
  localparam int unsigned LIMIT  = 150000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [VL_W-1:0] vl_i = '0;
  logic [1:0]      subvl_i = '0;
  logic            pack_i = 1'b0, unpack_i = 1'b0, vfirst_i = 1'b0;
  logic            issue_i = 1'b0, step_i = 1'b0;
  logic            busy_o, done_o;
  logic [VL_W-1:0] srcstep_o, dststep_o;
  logic [1:0]      ssubstep_o, dsubstep_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  ss_step_seq #(.MAX_VL(MAX_VL)) dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // expected position k of a loop, arithmetically
  task automatic chk_pos(input int k, input int vl, input int sv, input bit pk, input bit upk);
    int se, ss, de, ds;
    se = pk  ? k % vl : k / sv;
    ss = pk  ? k / vl : k % sv;
    de = upk ? k % vl : k / sv;
    ds = upk ? k / vl : k % sv;
    chk(pk ? "R4 srcstep" : "R3 srcstep", int'(srcstep_o), se);
    chk(pk ? "R4 ssubstep" : "R3 ssubstep", int'(ssubstep_o), ss);
    chk("R5 dststep", int'(dststep_o), de);
    chk("R5 dsubstep", int'(dsubstep_o), ds);
    chk("R10 busy", int'(busy_o), 1);
  endtask

  task automatic run(input int vl, input int sc, input bit pk, input bit upk, input bit vf);
    int sv;
    sv = sc + 1;
    start_i = 1'b1; vl_i = VL_W'(vl); subvl_i = 2'(sc);
    pack_i = pk; unpack_i = upk; vfirst_i = vf;
    tick();
    start_i = 1'b0;
    if (vl == 0) begin
      chk("R9 done", int'(done_o), 1);
      chk("R9 busy", int'(busy_o), 0);
      tick();
      chk("R9 done pulse", int'(done_o), 0);
      chk("R9 busy stays", int'(busy_o), 0);
      return;
    end
    chk("R2 busy", int'(busy_o), 1);
    chk("R2 zero", int'(srcstep_o) + int'(dststep_o) + int'(ssubstep_o) + int'(dsubstep_o), 0);
    for (int k = 0; k < vl * sv; k++) begin
      chk_pos(k, vl, sv, pk, upk);
      chk("R8 no early done", int'(done_o), 0);
      // strobe that this mode must ignore
      issue_i = vf; step_i = !vf;
      tick();
      issue_i = 1'b0; step_i = 1'b0;
      chk_pos(k, vl, sv, pk, upk);  // R6 / R7 hold
      chk(vf ? "R7 ignore issue" : "R6 ignore step", int'(srcstep_o), pk ? k % vl : k / sv);
      issue_i = !vf; step_i = vf;
      tick();
      issue_i = 1'b0; step_i = 1'b0;
    end
    chk("R8 done", int'(done_o), 1);
    chk("R8 idle", int'(busy_o), 0);
    chk("R8 zero", int'(srcstep_o) + int'(dststep_o) + int'(ssubstep_o) + int'(dsubstep_o), 0);
    tick();
    chk("R8 pulse", int'(done_o), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 steps", int'(srcstep_o) + int'(dststep_o) + int'(ssubstep_o) + int'(dsubstep_o), 0);
    rst_ni = 1'b1;
    tick();
    for (int vl = 0; vl <= 5; vl++)
      for (int sc = 0; sc < 4; sc++)
        for (int m = 0; m < 8; m++)
          run(vl, sc, m[0], m[1], m[2]);

    // R11: restart while busy
    start_i = 1'b1; vl_i = VL_W'(3); subvl_i = 2'd0; pack_i = 1'b0; unpack_i = 1'b0; vfirst_i = 1'b0;
    tick();
    start_i = 1'b0; issue_i = 1'b1;
    tick(); tick();
    issue_i = 1'b0;
    chk("R11 progressed", int'(srcstep_o), 2);
    start_i = 1'b1; vl_i = VL_W'(2); subvl_i = 2'd1; pack_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R11 busy", int'(busy_o), 1);
    chk("R11 cleared", int'(srcstep_o) + int'(ssubstep_o), 0);
    issue_i = 1'b1;
    tick();
    issue_i = 1'b0;
    chk("R11 new vl elem-inner", int'(srcstep_o), 1);
    chk("R11 new dst sub-inner", int'(dsubstep_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule